// File: doc/BRIEF.md
# Double-Buffered Timer Output Compare

This block is the compare stage of a 16-bit timer channel. It keeps a 16-bit compare value and checks it against the running count of an external counter on every clock. On equality it raises a sticky match flag, which software clears with a dedicated strobe. The stored value is also driven out continuously so that a counter can use it as its period limit.

Software reaches the 16-bit value through an 8-bit bus at two byte addresses. A high-byte write only parks the byte in a shared temporary latch. The following low-byte write then commits both bytes in a single cycle, so the comparator never sees a half-updated value. In the pulse-width modes the write lands in a shadow buffer. The buffer reaches the live register only when the counter signals the extreme that the current mode selects, which keeps pulse lengths consistent.

Top module: `tmr_compare16`

## Requirements
- R1: On reset the live compare value, the shadow buffer, the temporary high-byte latch and the match flag are all zero.
- R2: A write to the high-byte address (`bus_addr_hi` = 1) loads only the temporary latch. Neither `cmp_top` nor the value read back changes.
- R3: A write to the low-byte address (`bus_addr_hi` = 0) stores {latch, written byte} into the current target register in one clock. The result is visible on the next cycle.
- R4: Mode decode on the 4-bit `mode` code: codes 0, 4 and 12 are unbuffered; codes 8, 9, 10 and 11 are buffered and update when `at_bottom` is high; every other code is buffered and updates when `at_top` is high.
- R5: In an unbuffered mode, a low-byte write updates the live compare value, and the buffer with it. The new value appears on `cmp_top` the cycle after the write.
- R6: In a buffered mode, a low-byte write updates only the buffer. `cmp_top` keeps its previous value.
- R7: In a buffered mode, the buffer is copied to the live register on a clock where the selected strobe is high. The other strobe has no effect. Apart from this copy and R5 writes, the live value never changes.
- R8: When a low-byte write and a buffer copy fall on the same clock, the copy takes the buffer contents from before the write. The new value is copied at the next selected strobe.
- R9: `match_flag` goes high one cycle after a clock on which all 16 bits of `cnt` equal the live compare value. A partial match does not set it.
- R10: `match_flag` stays high until a clock with `flag_clr` high. If a match and `flag_clr` occur on the same clock, the flag stays set.
- R11: With `bus_rd` high, `bus_rdata` returns the low or high byte (chosen by `bus_addr_hi`) of the write target: the buffer in buffered modes, the live register otherwise. The high byte is read directly and never through the latch. With `bus_rd` low, `bus_rdata` is zero.
- R12: `cmp_top` always presents the live compare value used by the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Waveform mode code |
| cnt | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at its upper extreme |
| at_bottom | input | 1 | Counter is at zero |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read enable |
| bus_addr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| flag_clr | input | 1 | Clears the match flag |
| match_flag | output | 1 | Sticky compare match flag |
| cmp_top | output | 16 | Live compare value, usable as counter period |

## Verification
The properties assume that `at_top` and `at_bottom` are single-cycle strobes from a counter. They also assume that `mode` changes only on clocks with no bus write, so that each write is judged against one decoded mode. The properties predict the effect of a low-byte write from that clock's mode alone. The stimulus therefore changes `mode` only on an idle cycle before a write sequence, and it raises a strobe together with a write only in the one directed case that tests the collision ordering. The count is held at a value that cannot match, except in the flag tests where equality is the point.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    localparam int unsigned CMP_WIDTH  = 16;
    localparam int unsigned BUS_WIDTH  = 8;
    localparam int unsigned MODE_WIDTH = 4;

    typedef enum logic [1:0] {
        UPD_DIRECT    = 2'd0,
        UPD_AT_TOP    = 2'd1,
        UPD_AT_BOTTOM = 2'd2
    } upd_point_e;

    typedef struct packed {
        logic       buffered;
        upd_point_e point;
    } mode_cfg_t;

    typedef struct packed {
        logic hi_wr;
        logic lo_wr;
        logic rd;
        logic sel_hi;
    } bus_op_t;

    function automatic mode_cfg_t decode_mode(input logic [MODE_WIDTH-1:0] code);
        mode_cfg_t cfg;
        case (code)
            4'd0, 4'd4, 4'd12: cfg = '{buffered: 1'b0, point: UPD_DIRECT};
            4'd8, 4'd9, 4'd10, 4'd11: cfg = '{buffered: 1'b1, point: UPD_AT_BOTTOM};
            default: cfg = '{buffered: 1'b1, point: UPD_AT_TOP};
        endcase
        return cfg;
    endfunction

    function automatic bus_op_t split_bus(input logic wr, input logic rd, input logic hi);
        bus_op_t op;
        op.hi_wr  = wr & hi;
        op.lo_wr  = wr & ~hi;
        op.rd     = rd;
        op.sel_hi = hi;
        return op;
    endfunction

endpackage

// File: rtl/tmr_cmp_mode_dec.sv
module tmr_cmp_mode_dec
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned MODE_W = MODE_WIDTH
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              at_top,
    input  logic              at_bottom,
    output mode_cfg_t         cfg,
    output logic              xfer
);

    always_comb begin
        cfg = decode_mode(mode);
        unique case (cfg.point)
            UPD_AT_TOP:    xfer = cfg.buffered & at_top;
            UPD_AT_BOTTOM: xfer = cfg.buffered & at_bottom;
            default:       xfer = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_cmp_bus_if.sv
module tmr_cmp_bus_if
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned CMP_W = CMP_WIDTH,
    parameter int unsigned BUS_W = BUS_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr_hi,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CMP_W-1:0] rd_src,
    output logic             wr_stb,
    output logic [CMP_W-1:0] wr_value,
    output logic [BUS_W-1:0] bus_rdata
);

    localparam int unsigned HI_W = CMP_W - BUS_W;

    bus_op_t         op;
    logic [HI_W-1:0] hi_latch;

    assign op = split_bus(bus_wr, bus_rd, bus_addr_hi);

    // High-byte writes park their byte here until the low byte commits it.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_latch <= '0;
        end else if (op.hi_wr) begin
            hi_latch <= bus_wdata[HI_W-1:0];
        end
    end

    assign wr_stb   = op.lo_wr;
    assign wr_value = {hi_latch, bus_wdata};

    // Reads come straight from the target register; the latch is bypassed.
    always_comb begin
        if (!op.rd) begin
            bus_rdata = '0;
        end else if (op.sel_hi) begin
            bus_rdata = BUS_W'(rd_src[CMP_W-1:BUS_W]);
        end else begin
            bus_rdata = rd_src[BUS_W-1:0];
        end
    end

endmodule

// File: rtl/tmr_cmp_store.sv
module tmr_cmp_store
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned CMP_W = CMP_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_cfg_t        cfg,
    input  logic             xfer,
    input  logic             wr_stb,
    input  logic [CMP_W-1:0] wr_value,
    output logic [CMP_W-1:0] active_q,
    output logic [CMP_W-1:0] shadow_q,
    output logic [CMP_W-1:0] rd_src
);

    // The copy reads shadow_q before this edge, so a colliding write waits.
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            shadow_q <= '0;
        end else begin
            if (xfer) begin
                active_q <= shadow_q;
            end
            if (wr_stb) begin
                shadow_q <= wr_value;
                if (!cfg.buffered) begin
                    active_q <= wr_value;
                end
            end
        end
    end

    assign rd_src = cfg.buffered ? shadow_q : active_q;

endmodule

// File: rtl/tmr_cmp_match.sv
module tmr_cmp_match
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned CMP_W = CMP_WIDTH,
    parameter int unsigned BUS_W = BUS_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] cnt,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             flag_clr,
    output logic             match_flag
);

    localparam int unsigned SLICES = (CMP_W + BUS_W - 1) / BUS_W;

    logic [SLICES-1:0] slice_eq;
    logic              full_eq;

    // Compare one bus-width slice at a time, then combine the slices.
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        localparam int unsigned LO = s * BUS_W;
        localparam int unsigned HI = ((s + 1) * BUS_W > CMP_W) ? CMP_W - 1 : (s + 1) * BUS_W - 1;
        assign slice_eq[s] = (cnt[HI:LO] == cmp_val[HI:LO]);
    end

    assign full_eq = &slice_eq;

    // A set and a clear on the same clock leave the flag set.
    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag <= 1'b0;
        end else if (full_eq) begin
            match_flag <= 1'b1;
        end else if (flag_clr) begin
            match_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_compare16.sv
module tmr_compare16
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned CMP_W  = CMP_WIDTH,
    parameter int unsigned BUS_W  = BUS_WIDTH,
    parameter int unsigned MODE_W = MODE_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [CMP_W-1:0]  cnt,
    input  logic              at_top,
    input  logic              at_bottom,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr_hi,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              flag_clr,
    output logic              match_flag,
    output logic [CMP_W-1:0]  cmp_top
);

    mode_cfg_t        cfg;
    logic             xfer;
    logic             wr_stb;
    logic [CMP_W-1:0] wr_value;
    logic [CMP_W-1:0] active_q;
    logic [CMP_W-1:0] shadow_q;
    logic [CMP_W-1:0] rd_src;

    tmr_cmp_mode_dec #(.MODE_W(MODE_W)) u_dec (
        .mode      (mode),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .cfg       (cfg),
        .xfer      (xfer)
    );

    tmr_cmp_bus_if #(.CMP_W(CMP_W), .BUS_W(BUS_W)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr_hi (bus_addr_hi),
        .bus_wdata   (bus_wdata),
        .rd_src      (rd_src),
        .wr_stb      (wr_stb),
        .wr_value    (wr_value),
        .bus_rdata   (bus_rdata)
    );

    tmr_cmp_store #(.CMP_W(CMP_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .xfer     (xfer),
        .wr_stb   (wr_stb),
        .wr_value (wr_value),
        .active_q (active_q),
        .shadow_q (shadow_q),
        .rd_src   (rd_src)
    );

    tmr_cmp_match #(.CMP_W(CMP_W), .BUS_W(BUS_W)) u_match (
        .clk        (clk),
        .rst        (rst),
        .cnt        (cnt),
        .cmp_val    (active_q),
        .flag_clr   (flag_clr),
        .match_flag (match_flag)
    );

    assign cmp_top = active_q;

endmodule

// File: rtl/tmr_compare16_chk.sv
module tmr_compare16_chk
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned CMP_W  = CMP_WIDTH,
    parameter int unsigned BUS_W  = BUS_WIDTH,
    parameter int unsigned MODE_W = MODE_WIDTH
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode,
    input logic [CMP_W-1:0]  cnt,
    input logic              at_top,
    input logic              at_bottom,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr_hi,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              flag_clr,
    input logic              match_flag,
    input logic [CMP_W-1:0]  cmp_top
);

    logic buf_mode;
    logic lo_write;
    logic no_strobe;

    assign buf_mode  = decode_mode(mode).buffered;
    assign lo_write  = bus_wr & ~bus_addr_hi;
    assign no_strobe = ~at_top & ~at_bottom;

    assert_flag_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == cmp_top) |=> match_flag);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !flag_clr) |=> match_flag);

    assert_flag_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (match_flag && flag_clr && (cnt != cmp_top)) |=> !match_flag);

    assert_hi_write_inert_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr_hi && no_strobe) |=> $stable(cmp_top));

    assert_direct_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!buf_mode && lo_write) |=> (cmp_top[BUS_W-1:0] == $past(bus_wdata)));

    assert_buffered_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (buf_mode && lo_write && no_strobe) |=> $stable(cmp_top));

    assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!lo_write && no_strobe) |=> $stable(cmp_top));

    assert_read_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

endmodule

bind tmr_compare16 tmr_compare16_chk #(
    .CMP_W  (CMP_W),
    .BUS_W  (BUS_W),
    .MODE_W (MODE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .cnt         (cnt),
    .at_top      (at_top),
    .at_bottom   (at_bottom),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr_hi (bus_addr_hi),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .flag_clr    (flag_clr),
    .match_flag  (match_flag),
    .cmp_top     (cmp_top)
);

// File: tb/test_tmr_compare16.sv
`timescale 1ns/1ps
module test_tmr_compare16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = 4'd0;
    logic [15:0] cnt = 16'h5555;
    logic        at_top = 1'b0;
    logic        at_bottom = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr_hi = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        flag_clr = 1'b0;
    logic        match_flag;
    logic [15:0] cmp_top;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_compare16 i_tmr_compare16 (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .cnt         (cnt),
        .at_top      (at_top),
        .at_bottom   (at_bottom),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr_hi (bus_addr_hi),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .flag_clr    (flag_clr),
        .match_flag  (match_flag),
        .cmp_top     (cmp_top)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] val;
        logic [1:0]  stb;     // 0 none, 1 top, 2 bottom
        logic [15:0] exp_w;   // cmp_top after the write
        logic [15:0] exp_s;   // cmp_top after the strobe
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{4'd0,  16'h1234, 2'd0, 16'h1234, 16'h1234},
        '{4'd4,  16'hBEEF, 2'd1, 16'hBEEF, 16'hBEEF},
        '{4'd5,  16'h00FF, 2'd2, 16'hBEEF, 16'hBEEF},
        '{4'd5,  16'h0F0F, 2'd1, 16'hBEEF, 16'h0F0F},
        '{4'd9,  16'hA55A, 2'd1, 16'h0F0F, 16'h0F0F},
        '{4'd9,  16'h8001, 2'd2, 16'h0F0F, 16'h8001},
        '{4'd12, 16'hFFFF, 2'd0, 16'hFFFF, 16'hFFFF},
        '{4'd14, 16'h0000, 2'd1, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr_hi = hi; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] v);
        wr_byte(1'b1, v[15:8]);
        wr_byte(1'b0, v[7:0]);
    endtask

    task automatic strobe(input logic [1:0] s);
        at_top = (s == 2'd1); at_bottom = (s == 2'd2);
        tick();
        at_top = 1'b0; at_bottom = 1'b0;
    endtask

    task automatic rd_byte(input logic hi, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr_hi = hi;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, including the latch
        chk("R1 cmp_top after reset", cmp_top, 16'h0000);
        chk("R1 flag after reset", {15'd0, match_flag}, 16'h0000);
        mode = 4'd0;
        wr_byte(1'b0, 8'h77);
        chk("R1 latch zero after reset", cmp_top, 16'h0077);

        // Vector table: R3 R4 R5 R6 R7 R11
        for (int i = 0; i < NVEC; i++) begin
            mode = VEC[i].mode;
            tick();
            wr16(VEC[i].val);
            chk("R3 R5 R6 post-write", cmp_top, VEC[i].exp_w);
            rd_byte(1'b0, rb);
            chk("R11 read low", {8'h00, rb}, {8'h00, VEC[i].val[7:0]});
            rd_byte(1'b1, rb);
            chk("R11 read high", {8'h00, rb}, {8'h00, VEC[i].val[15:8]});
            strobe(VEC[i].stb);
            chk("R4 R7 post-strobe", cmp_top, VEC[i].exp_s);
        end

        // R2: high write touches only the latch
        mode = 4'd0;
        tick();
        wr_byte(1'b1, 8'hAB);
        chk("R2 cmp_top after high write", cmp_top, 16'h0000);
        rd_byte(1'b1, rb);
        chk("R2 R11 high read bypasses latch", {8'h00, rb}, 16'h0000);
        wr_byte(1'b0, 8'h11);
        chk("R3 commit both bytes", cmp_top, 16'hAB11);

        // R8: write colliding with a transfer
        mode = 4'd5;
        tick();
        wr16(16'h1111);
        chk("R6 buffered write held", cmp_top, 16'hAB11);
        wr_byte(1'b1, 8'h22);
        bus_wr = 1'b1; bus_addr_hi = 1'b0; bus_wdata = 8'h22; at_top = 1'b1;
        tick();
        bus_wr = 1'b0; at_top = 1'b0;
        chk("R8 transfer uses old buffer", cmp_top, 16'h1111);
        rd_byte(1'b0, rb);
        chk("R8 R11 buffer holds new value", {8'h00, rb}, 16'h0022);
        strobe(2'd1);
        chk("R8 new value at next update", cmp_top, 16'h2222);

        // R9 R10: match flag
        mode = 4'd0;
        tick();
        wr16(16'h0300);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R10 flag cleared", {15'd0, match_flag}, 16'h0000);
        cnt = 16'h0200; tick();
        chk("R9 partial match no flag", {15'd0, match_flag}, 16'h0000);
        cnt = 16'h0300; tick();
        chk("R9 full match sets flag", {15'd0, match_flag}, 16'h0001);
        chk("R12 cmp_top is live value", cmp_top, 16'h0300);
        cnt = 16'h0200; tick();
        chk("R10 flag sticky", {15'd0, match_flag}, 16'h0001);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R10 flag clear", {15'd0, match_flag}, 16'h0000);
        cnt = 16'h0300; flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R10 set wins over clear", {15'd0, match_flag}, 16'h0001);
        cnt = 16'h5555; flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R10 flag clear again", {15'd0, match_flag}, 16'h0000);

        // R11: idle read returns zero
        bus_rd = 1'b0; bus_addr_hi = 1'b1;
        #1;
        chk("R11 idle read zero", {8'h00, bus_rdata}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule